// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency input. It counts the rising edges of that input during a gate window of known length. The window length is measured in ticks of an external time base, with one tick standing for one millisecond. A two-bit select sets the window to one of four lengths. Before each window opens, the block waits for a settling interval, and the length of that wait depends on the window that was chosen. The IF input is asynchronous, so it passes through a synchroniser into the system clock domain before any edge is counted.

A controller starts a measurement by raising a start control level and clears the count by lowering that level. When done signalling is enabled, the block reports completion on a status line that behaves like an open-drain output. The line is released when a measurement starts. It is pulled low when the window closes, and it is released again when the controller opens a serial access with chip-enable. The same chip-enable rise loads the count into a shift register. The controller then clocks the count out most significant bit first with single-cycle shift strobes.

Top module: `ifc_gated_counter`

## Requirements
- R1: After reset the status line is released (`status_low` = 0), `ser_out` is 0, and a serial read returns a count of 0.
- R2: `gate_sel` values 0, 1, 2 and 3 select windows of `WIN_T0`, `WIN_T1`, `WIN_T2` and `WIN_T3` ticks (defaults 4, 8, 32 and 64). The count equals the number of rising IF edges that fall inside that window.
- R3: Between the start and the opening of the window, the block waits `WAIT_SHORT` ticks (default 4) when `gate_sel[1]` = 0 and `WAIT_LONG` ticks (default 8) when `gate_sel[1]` = 1. Completion is signalled on the last tick of the window and never earlier.
- R4: Only rising edges of the synchronised IF input are counted, and a level that stays high adds nothing. The count stops at 2^`COUNT_W`-1 and does not wrap.
- R5: While `start_bit` is 0 the count is held at 0, and a window that is in progress is abandoned.
- R6: With `done_sel` = 1, a 0-to-1 change of `start_bit` releases the status line, and the end of the window pulls it low (`status_low` = 1). With `done_sel` = 0 the line is not changed by either event. Lowering `start_bit` does not release it.
- R7: A rise of `cs_active` releases the status line one clock later.
- R8: A rise of `cs_active` loads the count. `ser_out` shows bit `COUNT_W`-1 first, and each cycle with `shift_en` = 1 moves the next lower bit onto `ser_out`.
- R9: The value of `gate_sel` is captured when the measurement starts. Changing it later has no effect on that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_in | input | 1 | IF signal, asynchronous to clk |
| tick | input | 1 | One-cycle time-base pulse, one per millisecond unit |
| start_bit | input | 1 | 1 = run a measurement, 0 = hold the count cleared |
| gate_sel | input | 2 | Window select |
| done_sel | input | 1 | Enables completion reporting on the status line |
| cs_active | input | 1 | Chip-enable of the serial access |
| shift_en | input | 1 | Shift strobe for the result register |
| ser_out | output | 1 | Serial result, MSB first |
| status_low | output | 1 | 1 = status line pulled low, 0 = released |

## Verification
A tick miscount in the wait or window sequencer moves the status pull-low to a different tick. The bench samples the line one cycle before and one cycle after the expected tick, so such an error shows within one clock cycle. A wrong edge counter, a wrong saturation limit or a wrong gate length shows up in the serialised count at the next chip-enable access. The IF stimulus is phase-locked to the tick, which makes every expected count exact rather than correct only to within one edge. A latched-select or clear fault appears as a count or a status level that does not match the captured window, and it is visible on the read that follows.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_GATE = 2'd2,
      ST_DONE = 2'd3
   } meas_state_t;

   function automatic int unsigned max4(int unsigned a, int unsigned b,
                                        int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ifc_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   for (genvar i = 0; i <= STAGES; i++) begin : g_chain
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   // chain[STAGES-1] is the synchronised level; chain[STAGES] is its delayed copy
   assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ifc_gate_seq.sv
module ifc_gate_seq
   import ifc_pkg::*;
#(
   parameter int unsigned WIN_T0     = 4,
   parameter int unsigned WIN_T1     = 8,
   parameter int unsigned WIN_T2     = 32,
   parameter int unsigned WIN_T3     = 64,
   parameter int unsigned WAIT_SHORT = 4,
   parameter int unsigned WAIT_LONG  = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        start_lvl,
   input  logic        start_rise,
   input  logic [1:0]  gate_sel,
   output meas_state_t state,
   output logic        done_evt
);
   localparam int unsigned MAX_LEN = max4(max4(WIN_T0, WIN_T1, WIN_T2, WIN_T3),
                                          WAIT_SHORT, WAIT_LONG, 1);
   localparam int unsigned TICK_W  = $clog2(MAX_LEN + 1);

   logic [1:0]        sel_q;
   logic [TICK_W-1:0] tcnt;
   logic [TICK_W-1:0] wait_last;
   logic [TICK_W-1:0] win_last;

   always_comb begin
      wait_last = sel_q[1] ? TICK_W'(WAIT_LONG - 1) : TICK_W'(WAIT_SHORT - 1);
      unique case (sel_q)
         2'd0:    win_last = TICK_W'(WIN_T0 - 1);
         2'd1:    win_last = TICK_W'(WIN_T1 - 1);
         2'd2:    win_last = TICK_W'(WIN_T2 - 1);
         default: win_last = TICK_W'(WIN_T3 - 1);
      endcase
   end

   assign done_evt = (state == ST_GATE) && tick && (tcnt == win_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tcnt  <= '0;
         sel_q <= 2'd0;
      end else if (!start_lvl) begin
         state <= ST_IDLE;
         tcnt  <= '0;
      end else if (start_rise) begin
         state <= ST_WAIT;
         tcnt  <= '0;
         sel_q <= gate_sel;
      end else if (tick) begin
         unique case (state)
            ST_WAIT: begin
               if (tcnt == wait_last) begin
                  state <= ST_GATE;
                  tcnt  <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_GATE: begin
               if (tcnt == win_last) begin
                  state <= ST_DONE;
                  tcnt  <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: tcnt <= '0;
         endcase
      end
   end

   // R3: the window opens only out of the settling wait
   a_r3_gate_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GATE && $past(state) != ST_GATE) |-> $past(state) == ST_WAIT);
   // R2: completion is reached only from an open window
   a_r2_done_from_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && $past(state) != ST_DONE) |-> $past(state) == ST_GATE);
   // R9: captured select holds through wait and window
   a_r9_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state inside {ST_WAIT, ST_GATE} && $past(state) inside {ST_WAIT, ST_GATE})
      |-> $stable(sel_q));
endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
   parameter int unsigned COUNT_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               inc,
   output logic [COUNT_W-1:0] count
);
   localparam logic [COUNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         count <= '0;
      else if (clear)                     count <= '0;
      else if (inc && (count != CNT_MAX)) count <= count + 1'b1;
   end

   // R4: a full counter stays full instead of wrapping
   a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(count) == CNT_MAX && !$past(clear)) |-> count == CNT_MAX);
   // R4: without a clear the count moves by at most one per cycle
   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clear) |-> (count == $past(count) || count == $past(count) + 1'b1));
endmodule

// File: rtl/ifc_result_shift.sv
module ifc_result_shift #(
   parameter int unsigned COUNT_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [COUNT_W-1:0] load_val,
   input  logic               shift,
   output logic               ser_out
);
   logic [COUNT_W-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sreg <= '0;
      else if (load)  sreg <= load_val;
      else if (shift) sreg <= {sreg[COUNT_W-2:0], 1'b0};
   end

   assign ser_out = sreg[COUNT_W-1];

   // R8: the serial output moves only on a load or a shift
   a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && !$past(shift)) |-> $stable(ser_out));
endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter
   import ifc_pkg::*;
#(
   parameter int unsigned COUNT_W     = 20,
   parameter int unsigned SYNC_STAGES = 2,
   // window and wait lengths in time-base ticks (one tick = 1 ms)
   parameter int unsigned WIN_T0      = 4,
   parameter int unsigned WIN_T1      = 8,
   parameter int unsigned WIN_T2      = 32,
   parameter int unsigned WIN_T3      = 64,
   parameter int unsigned WAIT_SHORT  = 4,
   parameter int unsigned WAIT_LONG   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       if_in,
   input  logic       tick,
   input  logic       start_bit,
   input  logic [1:0] gate_sel,
   input  logic       done_sel,
   input  logic       cs_active,
   input  logic       shift_en,
   output logic       ser_out,
   output logic       status_low
);
   if (COUNT_W < 2) begin : g_bad_width
      $error("ifc_gated_counter: COUNT_W must be at least 2");
   end
   if (WIN_T0 < 1 || WIN_T1 < 1 || WIN_T2 < 1 || WIN_T3 < 1) begin : g_bad_win
      $error("ifc_gated_counter: window lengths must be nonzero");
   end
   if (WAIT_SHORT < 1 || WAIT_LONG < 1) begin : g_bad_wait
      $error("ifc_gated_counter: wait lengths must be nonzero");
   end

   logic               start_q;
   logic               cs_q;
   logic               start_rise;
   logic               cs_rise;
   logic               if_rise;
   logic               done_evt;
   meas_state_t        state;
   logic [COUNT_W-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         cs_q    <= 1'b0;
      end else begin
         start_q <= start_bit;
         cs_q    <= cs_active;
      end
   end

   assign start_rise = start_bit & ~start_q;
   assign cs_rise    = cs_active & ~cs_q;

   ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .async_in   (if_in),
      .rise_pulse (if_rise)
   );

   ifc_gate_seq #(
      .WIN_T0     (WIN_T0),
      .WIN_T1     (WIN_T1),
      .WIN_T2     (WIN_T2),
      .WIN_T3     (WIN_T3),
      .WAIT_SHORT (WAIT_SHORT),
      .WAIT_LONG  (WAIT_LONG)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .start_lvl  (start_bit),
      .start_rise (start_rise),
      .gate_sel   (gate_sel),
      .state      (state),
      .done_evt   (done_evt)
   );

   ifc_sat_counter #(.COUNT_W(COUNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (~start_bit | start_rise),
      .inc   ((state == ST_GATE) & if_rise),
      .count (count)
   );

   ifc_result_shift #(.COUNT_W(COUNT_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cs_rise),
      .load_val (count),
      .shift    (shift_en),
      .ser_out  (ser_out)
   );

   // status line: a bus access releases it first, then completion, then start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     status_low <= 1'b0;
      else if (cs_rise)               status_low <= 1'b0;
      else if (done_evt && done_sel)  status_low <= 1'b1;
      else if (start_rise && done_sel) status_low <= 1'b0;
   end

   // R7: chip-enable rise releases the status line
   a_r7_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_active) |=> !status_low);
   // R6: completion with reporting enabled pulls the line low
   a_r6_done_low: assert property (@(posedge clk) disable iff (!rst_n)
      (done_evt && done_sel && !cs_rise) |=> status_low);
   // R5: start level low keeps the count at zero
   a_r5_clear_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start_bit |=> (count == '0));
   // R6: without reporting, the line never falls from released to low
   a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_sel && !status_low) |=> !status_low);
endmodule

// File: tb/tb_ifc_gated_counter.sv
module tb_ifc_gated_counter;
   localparam int TPER    = 12;   // clock cycles per time-base tick
   localparam int NVEC    = 5;
   localparam int SAT_W   = 6;
   localparam int WINS[4] = '{4, 8, 32, 64};
   localparam int WAITS[4] = '{4, 4, 8, 8};
   // vector table: gate select, IF period in cycles, done reporting, expected count
   localparam int V_SEL[NVEC]  = '{0, 1, 2, 3, 0};
   localparam int V_PER[NVEC]  = '{4, 3, 6, 2, 12};
   localparam int V_DONE[NVEC] = '{1, 1, 0, 1, 1};
   localparam int V_EXP[NVEC]  = '{12, 32, 64, 384, 4};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic if_in = 1'b0;
   logic tick = 1'b0;
   logic start_bit = 1'b0;
   logic [1:0] gate_sel = 2'd0;
   logic done_sel = 1'b0;
   logic cs_active = 1'b0;
   logic shift_en = 1'b0;
   logic ser_out, status_low, sat_ser, sat_status;

   int checks = 0;
   int fails = 0;
   int tcnt = 0;
   int ntick = 0;
   int ifp = 0;
   int per = 4;
   int cycles = 0;
   logic [31:0] rd_main, rd_sat;

   always #2 clk = ~clk;

   ifc_gated_counter dut (
      .clk(clk), .rst_n(rst_n), .if_in(if_in), .tick(tick), .start_bit(start_bit),
      .gate_sel(gate_sel), .done_sel(done_sel), .cs_active(cs_active),
      .shift_en(shift_en), .ser_out(ser_out), .status_low(status_low));

   ifc_gated_counter #(.COUNT_W(SAT_W)) dut_sat (
      .clk(clk), .rst_n(rst_n), .if_in(if_in), .tick(tick), .start_bit(start_bit),
      .gate_sel(gate_sel), .done_sel(done_sel), .cs_active(cs_active),
      .shift_en(shift_en), .ser_out(sat_ser), .status_low(sat_status));

   // time base and IF pattern, phase-locked, updated at the falling edge
   always @(negedge clk) begin
      tcnt = (tcnt == TPER - 1) ? 0 : tcnt + 1;
      tick = (tcnt == 0);
      if (tick) ntick = ntick + 1;
      if (per == 0) begin
         if_in = 1'b1;
      end else begin
         ifp = (ifp >= per - 1) ? 0 : ifp + 1;
         if_in = (ifp == 0);
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (cycles > 150000) begin
         checks = checks + 1;
         fails = fails + 1;
         $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cycles);
         finish_run();
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk); #1;
   endtask

   // chip-enable access: load on rise, then read MSB first
   task automatic serial_read();
      cs_active = 1'b1;
      step();
      rd_main = '0;
      rd_sat = '0;
      for (int i = 0; i < 20; i++) begin
         rd_main = {rd_main[30:0], ser_out};
         if (i < SAT_W) rd_sat = {rd_sat[30:0], sat_ser};
         shift_en = 1'b1;
         step();
      end
      shift_en = 1'b0;
      cs_active = 1'b0;
      step();
   endtask

   task automatic start_mid_tick(output int n0);
      while (tcnt != TPER / 2) step();
      start_bit = 1'b1;
      n0 = ntick;
   endtask

   task automatic wait_tick(int target);
      while (ntick != target) step();
   endtask

   initial begin
      int n0;
      repeat (5) step();
      // R1: reset state
      chk("R1 status after reset", status_low, 0);
      chk("R1 ser_out after reset", ser_out, 0);
      rst_n = 1'b1;
      repeat (3) step();
      serial_read();
      chk("R1 count after reset", rd_main, 0);
      chk("R1 status released", status_low, 0);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         gate_sel = 2'(V_SEL[v]);
         done_sel = V_DONE[v][0];
         per = V_PER[v];
         repeat (2 * TPER) step();
         start_mid_tick(n0);
         wait_tick(n0 + WAITS[V_SEL[v]] + WINS[V_SEL[v]]);
         chk("R3 no early completion", status_low, 0);
         @(posedge clk); #1;
         chk("R2/R6 status at window end", status_low, 32'(V_DONE[v]));
         step();
         serial_read();
         chk("R2 count for window", rd_main, 32'(V_EXP[v]));
         chk("R4 saturating count", rd_sat, (V_EXP[v] > 63) ? 32'd63 : 32'(V_EXP[v]));
         chk("R7 status after access", status_low, 0);
         start_bit = 1'b0;
         step();
      end

      // R9: select changed during the wait is ignored
      gate_sel = 2'd0;
      done_sel = 1'b1;
      per = 4;
      repeat (2 * TPER) step();
      start_mid_tick(n0);
      repeat (TPER) step();
      gate_sel = 2'd3;
      wait_tick(n0 + 8);
      chk("R9 no early completion", status_low, 0);
      @(posedge clk); #1;
      chk("R9 completes on captured window", status_low, 1);

      // R6: lowering start keeps the line low, raising it releases
      start_bit = 1'b0;
      repeat (3) step();
      chk("R6 clear does not release", status_low, 1);
      start_bit = 1'b1;
      step();
      chk("R6 start releases", status_low, 0);

      // R5: abandon mid-wait, count held at zero, no completion
      repeat (2 * TPER) step();
      start_bit = 1'b0;
      repeat (120 * TPER / 10) step();
      chk("R5 abandoned measurement silent", status_low, 0);
      serial_read();
      chk("R5 count cleared", rd_main, 0);

      // R4: steady high input gives no edges inside the window
      per = 0;
      gate_sel = 2'd1;
      repeat (2 * TPER) step();
      start_mid_tick(n0);
      wait_tick(n0 + 12);
      @(posedge clk); #1;
      chk("R4 level gives completion", status_low, 1);
      serial_read();
      chk("R4 level counts nothing", rd_main, 0);

      // R8: MSB first ordering on a pattern with distinct ends
      start_bit = 1'b0;
      step();
      per = 3;
      gate_sel = 2'd3;
      repeat (2 * TPER) step();
      start_mid_tick(n0);
      wait_tick(n0 + 72);
      @(posedge clk); #1;
      step();
      serial_read();
      chk("R8 MSB-first value", rd_main, 256);
      start_bit = 1'b0;
      step();

      finish_run();
   end
endmodule